// File: doc/BRIEF.md
# Multi-domain clock enable generator

This block runs on a single fast system clock and turns it into single-cycle enable strobes for a family of derived domains. The domains are a bus domain, a CPU domain and a copy of the CPU domain delayed by two cycles, three peripheral domains divided down from the bus rate, and two asynchronous-peripheral domains that follow a selectable parent. Logic in a derived domain stays on the system clock and advances only in cycles where its strobe is high.

A small write-only register port sets the configuration. It holds a per-domain disable mask, three peripheral divide ratios, a self-test divider for the CPU pair, and the parent selection for the asynchronous domains. A divide-ratio write that would make peripheral domain 2 run at a rate that is not an integer multiple of the rate of peripheral domain 1 is refused, and the refusal is flagged. Every strobe is qualified by the disable mask, and disabling the bus domain silences every domain derived from it.

Top module: `clk_en_gen`

## Requirements
- R1: After reset the mask is clear, every divider divides by 1, self-test is off, the async parents are peripheral domain 1 and the error flag is low. Bus, CPU, peripheral and async strobes are then high every cycle, and the delayed CPU strobe goes high two clock edges after reset is released.
- R2: A write to address 1 sets the peripheral ratios, each field holding ratio minus 1: bits [3:0] for domain 1, [7:4] for domain 2, [11:8] for domain 3. Once settled, peripheral domain k pulses exactly once every N_k cycles, with N_k from 1 to 16.
- R3: A write to address 0 sets the disable mask: bit 0 CPU, bit 1 bus, bit 2 peripheral 1, bit 3 peripheral 2, bit 8 peripheral 3, bit 4 async 0, bit 5 async 1. A set bit holds its domain's strobe low and leaves the other domains alone.
- R4: While mask bit 1 is set, no output strobe of any domain goes high.
- R5: Outside self-test, the CPU strobe is high in every cycle in which the bus strobe is high, unless mask bit 0 is set.
- R6: The delayed CPU strobe equals the CPU strobe of two cycles earlier while the gating is steady, and it is low whenever the CPU domain is disabled.
- R7: A write to address 2 sets self-test: bit 0 enables it, bits [3:1] hold ratio minus 1 (1 to 8). While it is on, the CPU strobe and its delayed copy pulse once every ratio cycles.
- R8: A peripheral ratio write is accepted only if the domain 1 ratio is divisible by the domain 2 ratio. Otherwise all three ratios keep their old values and the error output goes high in the next cycle.
- R9: The error output stays high until a write to address 3 with bit 7 set clears it.
- R10: A write to address 3 sets the async parents: bit 0 for async 0 and bit 1 for async 1, where 0 selects peripheral domain 1 and 1 selects the bus domain. Each async strobe is its parent's strobe masked by its own bit.
- R11: A new divide ratio takes effect only at the divider's next terminal count, so the interval in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 12 | Register write data |
| bus_en_o | output | 1 | Bus domain enable |
| cpu_en_o | output | 1 | CPU domain enable |
| cpu_dly_en_o | output | 1 | Delayed CPU domain enable |
| per_en_o | output | 3 | Peripheral domain enables, bit k for domain k+1 |
| asy_en_o | output | 2 | Async peripheral domain enables |
| ratio_err_o | output | 1 | Sticky flag for a refused ratio write |

## Verification
The bench changes a divider while an interval is in progress. A design that reloaded the counter at once would emit a short interval that the bench detects. It sends ratio pairs that break the multiple rule and then measures the intervals, which exposes a design that half-applies a refused write or fails to raise the flag. It sweeps each mask bit on its own, which catches swapped positions such as peripheral 3 being read from bit 4 instead of bit 8. It also compares the delayed CPU strobe cycle by cycle against the CPU strobe under self-test, which shows an off-by-one lag or a copy that runs while the CPU domain is off.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
  localparam int N_PER  = 3;
  localparam int N_ASY  = 2;
  localparam int PDIV_W = 4;
  localparam int SDIV_W = 3;
  localparam int ADDR_W = 2;
  localparam int DATA_W = N_PER * PDIV_W;

  localparam int BIT_CPU     = 0;
  localparam int BIT_BUS     = 1;
  localparam int ASY_CLR_BIT = 7;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PDIV = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STST = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ASY  = 2'd3;

  // mask bit of peripheral domain i (third domain sits at bit 8)
  function automatic int per_mask_bit(int i);
    return (i == 2) ? 8 : 2 + i;
  endfunction

  function automatic int asy_mask_bit(int i);
    return 4 + i;
  endfunction

  typedef struct packed {
    logic                          cpu_off;
    logic                          bus_off;
    logic [N_PER-1:0]              per_off;
    logic [N_ASY-1:0]              asy_off;
    logic [N_PER-1:0][PDIV_W-1:0]  pdiv_m1;
    logic                          st_on;
    logic [SDIV_W-1:0]             sdiv_m1;
    logic [N_ASY-1:0]              asy_sel;
    logic                          err;
  } cfg_t;
endpackage

// File: rtl/clk_en_regs.sv
module clk_en_regs
  import clk_en_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o
);
  localparam int RW = PDIV_W + 1;

  cfg_t q;
  logic [N_PER-1:0][PDIV_W-1:0] new_div;
  logic [RW-1:0] n1, n2;
  logic ratio_ok;

  always_comb begin
    for (int i = 0; i < N_PER; i++) new_div[i] = wr_data_i[i*PDIV_W +: PDIV_W];
  end

  assign n1       = {1'b0, new_div[0]} + RW'(1);
  assign n2       = {1'b0, new_div[1]} + RW'(1);
  assign ratio_ok = (n1 % n2) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_MASK: begin
          q.cpu_off <= wr_data_i[BIT_CPU];
          q.bus_off <= wr_data_i[BIT_BUS];
          for (int i = 0; i < N_PER; i++) q.per_off[i] <= wr_data_i[per_mask_bit(i)];
          for (int i = 0; i < N_ASY; i++) q.asy_off[i] <= wr_data_i[asy_mask_bit(i)];
        end
        ADDR_PDIV: begin
          if (ratio_ok) q.pdiv_m1 <= new_div;
          else          q.err     <= 1'b1;
        end
        ADDR_STST: begin
          q.st_on   <= wr_data_i[0];
          q.sdiv_m1 <= wr_data_i[SDIV_W:1];
        end
        ADDR_ASY: begin
          q.asy_sel <= wr_data_i[N_ASY-1:0];
          if (wr_data_i[ASY_CLR_BIT]) q.err <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = q;
endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_m1_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  // ratio sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (tc_o) cnt_q <= ratio_m1_i;
    else          cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
  import clk_en_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              bus_en_o,
  output logic              cpu_en_o,
  output logic              cpu_dly_en_o,
  output logic [N_PER-1:0]  per_en_o,
  output logic [N_ASY-1:0]  asy_en_o,
  output logic              ratio_err_o
);
  cfg_t cfg;
  logic bus_on, cpu_on, st_tc, cpu_raw;
  logic [1:0] dly_q;

  clk_en_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  assign bus_on   = ~cfg.bus_off;
  assign cpu_on   = bus_on & ~cfg.cpu_off;
  assign bus_en_o = bus_on;

  clk_en_div #(.W(SDIV_W)) u_st_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_m1_i (cfg.sdiv_m1),
    .tc_o       (st_tc)
  );

  assign cpu_raw = cfg.st_on ? st_tc : 1'b1;

  // delay line runs ungated; gating applied at the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= {dly_q[0], cpu_raw};
  end

  assign cpu_en_o     = cpu_on & cpu_raw;
  assign cpu_dly_en_o = cpu_on & dly_q[1];

  for (genvar g = 0; g < N_PER; g++) begin : g_per
    logic tc;
    clk_en_div #(.W(PDIV_W)) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ratio_m1_i (cfg.pdiv_m1[g]),
      .tc_o       (tc)
    );
    assign per_en_o[g] = tc & bus_on & ~cfg.per_off[g];
  end

  for (genvar g = 0; g < N_ASY; g++) begin : g_asy
    logic parent;
    assign parent      = cfg.asy_sel[g] ? bus_en_o : per_en_o[0];
    assign asy_en_o[g] = parent & ~cfg.asy_off[g];
  end

  assign ratio_err_o = cfg.err;
endmodule

// File: rtl/clk_en_gen_chk.sv
module clk_en_gen_chk
  import clk_en_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              bus_en_o,
  input logic              cpu_en_o,
  input logic              cpu_dly_en_o,
  input logic [N_PER-1:0]  per_en_o,
  input logic [N_ASY-1:0]  asy_en_o,
  input logic              ratio_err_o,
  input cfg_t              cfg
);
  logic [1:0] cyc_q;
  logic [1:0] gate;
  logic [PDIV_W:0] w1, w2, s1, s2;
  logic wr_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign gate   = {cfg.bus_off, cfg.cpu_off};
  assign w1     = {1'b0, wr_data_i[PDIV_W-1:0]} + 5'd1;
  assign w2     = {1'b0, wr_data_i[2*PDIV_W-1:PDIV_W]} + 5'd1;
  assign s1     = {1'b0, cfg.pdiv_m1[0]} + 5'd1;
  assign s2     = {1'b0, cfg.pdiv_m1[1]} + 5'd1;
  assign wr_bad = wr_en_i && (wr_addr_i == ADDR_PDIV) && ((w1 % w2) != '0);

  p_bus_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.bus_off |-> !(bus_en_o || cpu_en_o || cpu_dly_en_o || (|per_en_o) || (|asy_en_o)));

  p_cpu_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.cpu_off |-> (!cpu_en_o && !cpu_dly_en_o));

  p_cpu_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.st_on && bus_en_o && !cfg.cpu_off) |-> cpu_en_o);

  p_dly_lag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && gate == $past(gate) && $past(gate) == $past(gate, 2) && cpu_dly_en_o)
      |-> $past(cpu_en_o, 2));

  p_err_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ratio_err_o) |-> $past(wr_en_i && wr_addr_i == ADDR_PDIV));

  p_keep_ratio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> $stable(cfg.pdiv_m1));

  p_multiple_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1 % s2) == '0);

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_err_o && !(wr_en_i && wr_addr_i == ADDR_ASY && wr_data_i[ASY_CLR_BIT]))
      |=> ratio_err_o);
endmodule

bind clk_en_gen clk_en_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .bus_en_o     (bus_en_o),
  .cpu_en_o     (cpu_en_o),
  .cpu_dly_en_o (cpu_dly_en_o),
  .per_en_o     (per_en_o),
  .asy_en_o     (asy_en_o),
  .ratio_err_o  (ratio_err_o),
  .cfg          (cfg)
);

// File: tb/clk_en_gen_tb.sv
module clk_en_gen_tb;
  import clk_en_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic bus_en, cpu_en, cpu_dly_en, ratio_err;
  logic [N_PER-1:0] per_en;
  logic [N_ASY-1:0] asy_en;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  clk_en_gen u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .bus_en_o     (bus_en),
    .cpu_en_o     (cpu_en),
    .cpu_dly_en_o (cpu_dly_en),
    .per_en_o     (per_en),
    .asy_en_o     (asy_en),
    .ratio_err_o  (ratio_err)
  );

  // {ratio1, ratio2, ratio3, accepted}
  localparam int VEC [8][4] = '{
    '{1, 1, 1, 1}, '{4, 2, 3, 1}, '{16, 8, 5, 1}, '{6, 3, 16, 1},
    '{5, 2, 7, 0}, '{2, 4, 1, 0}, '{8, 8, 2, 1}, '{12, 4, 9, 1}
  };

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int pword(int a, int b, int c);
    return (a - 1) | ((b - 1) << 4) | ((c - 1) << 8);
  endfunction

  // intervals of each peripheral strobe; async 0 must track peripheral 1
  task automatic gaps(int e0, int e1, int e2, string req);
    int exp_g [3];
    int last [3];
    int bad [3];
    int seen [3];
    int asy_mis = 0;
    exp_g[0] = e0; exp_g[1] = e1; exp_g[2] = e2;
    for (int i = 0; i < 3; i++) begin last[i] = -1; bad[i] = 0; seen[i] = 0; end
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (asy_en[0] != per_en[0]) asy_mis++;
      for (int i = 0; i < 3; i++) begin
        if (per_en[i]) begin
          if (last[i] >= 0) begin
            seen[i]++;
            if (c - last[i] != exp_g[i] && bad[i] == 0) bad[i] = c - last[i];
          end
          last[i] = c;
        end
      end
    end
    for (int i = 0; i < 3; i++)
      chk(req, $sformatf("peripheral %0d interval", i + 1),
          (seen[i] == 0) ? -1 : ((bad[i] != 0) ? bad[i] : exp_g[i]), exp_g[i]);
    chk("R10", "async 0 vs peripheral 1 mismatches", asy_mis, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cur [3];
    int t;
    int cnt0, cnt1, mis, last_c, bad_g;
    logic cpu_h [64];

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "bus", int'(bus_en), 1);
    chk("R1", "cpu", int'(cpu_en), 1);
    chk("R1", "dly at release", int'(cpu_dly_en), 0);
    chk("R1", "per", int'(per_en), 7);
    chk("R1", "asy", int'(asy_en), 3);
    chk("R1", "err", int'(ratio_err), 0);
    repeat (2) @(negedge clk);
    chk("R1", "dly after two edges", int'(cpu_dly_en), 1);

    // vector table: R2, R8, R9
    cur[0] = 1; cur[1] = 1; cur[2] = 1;
    for (int v = 0; v < 8; v++) begin
      wr(ADDR_PDIV, pword(VEC[v][0], VEC[v][1], VEC[v][2]));
      chk("R8", $sformatf("err after vector %0d", v), int'(ratio_err), 1 - VEC[v][3]);
      if (VEC[v][3] != 0) begin
        for (int i = 0; i < 3; i++) cur[i] = VEC[v][i];
      end else begin
        repeat (5) @(negedge clk);
        chk("R9", "err held", int'(ratio_err), 1);
        wr(ADDR_ASY, 1 << ASY_CLR_BIT);
        chk("R9", "err cleared", int'(ratio_err), 0);
      end
      repeat (40) @(negedge clk);
      gaps(cur[0], cur[1], cur[2], "R2");
    end

    // mask positions: R3, R4
    wr(ADDR_PDIV, 0);
    wr(ADDR_MASK, 1 << 1);
    cnt0 = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      cnt0 += int'(bus_en) + int'(cpu_en) + int'(cpu_dly_en) + $countones(per_en) + $countones(asy_en);
    end
    chk("R4", "strobes with bus off", cnt0, 0);
    wr(ADDR_MASK, 1 << 0);
    chk("R3", "cpu off: cpu", int'(cpu_en), 0);
    chk("R6", "cpu off: dly", int'(cpu_dly_en), 0);
    chk("R3", "cpu off: bus", int'(bus_en), 1);
    chk("R3", "cpu off: per", int'(per_en), 7);
    wr(ADDR_MASK, 1 << 8);
    chk("R3", "bit8: per", int'(per_en), 3);
    chk("R3", "bit8: cpu", int'(cpu_en), 1);
    wr(ADDR_MASK, 1 << 2);
    chk("R3", "bit2: per", int'(per_en), 6);
    chk("R10", "bit2: asy follow p1", int'(asy_en), 0);
    wr(ADDR_MASK, 1 << 3);
    chk("R3", "bit3: per", int'(per_en), 5);
    wr(ADDR_MASK, 1 << 4);
    chk("R3", "bit4: asy", int'(asy_en), 2);
    wr(ADDR_MASK, 1 << 5);
    chk("R3", "bit5: asy", int'(asy_en), 1);
    wr(ADDR_MASK, 0);

    // async parent select: R10
    wr(ADDR_PDIV, pword(4, 2, 1));
    wr(ADDR_ASY, 1);
    repeat (20) @(negedge clk);
    cnt0 = 0; cnt1 = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cnt0 += int'(asy_en[0]);
      cnt1 += int'(asy_en[1]);
    end
    chk("R10", "async 0 on bus", cnt0, 16);
    chk("R10", "async 1 on p1", cnt1, 4);
    wr(ADDR_ASY, 0);

    // self-test ratio 4: R7, R6, R5
    wr(ADDR_STST, (3 << 1) | 1);
    repeat (20) @(negedge clk);
    mis = 0; cnt0 = 0; last_c = -1; bad_g = 0; cnt1 = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      cpu_h[c] = cpu_en;
      cnt1 += int'(bus_en);
      if (c >= 2 && cpu_dly_en != cpu_h[c-2]) mis++;
      if (cpu_en) begin
        cnt0++;
        if (last_c >= 0 && c - last_c != 4 && bad_g == 0) bad_g = c - last_c;
        last_c = c;
      end
    end
    chk("R7", "cpu pulses at ratio 4", cnt0, 10);
    chk("R7", "cpu interval ratio 4", (bad_g != 0) ? bad_g : 4, 4);
    chk("R6", "dly lag mismatches", mis, 0);
    chk("R5", "bus undivided in self-test", cnt1, 40);

    wr(ADDR_STST, (7 << 1) | 1);
    repeat (20) @(negedge clk);
    last_c = -1; bad_g = 0; cnt0 = 0;
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      if (cpu_en) begin
        cnt0++;
        if (last_c >= 0 && c - last_c != 8 && bad_g == 0) bad_g = c - last_c;
        last_c = c;
      end
    end
    chk("R7", "cpu pulses at ratio 8", cnt0, 6);
    chk("R7", "cpu interval ratio 8", (bad_g != 0) ? bad_g : 8, 8);

    wr(ADDR_STST, 0);
    mis = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (cpu_en != 1'b1 || bus_en != 1'b1) mis++;
    end
    chk("R5", "cpu every bus cycle", mis, 0);

    // ratio change mid-interval: R11
    wr(ADDR_PDIV, pword(8, 8, 1));
    repeat (30) @(negedge clk);
    t = 0;
    while (!per_en[0] && t < 40) begin @(negedge clk); t++; end
    t = 0;
    repeat (2) @(negedge clk);
    t = 2;
    wr(ADDR_PDIV, pword(2, 2, 1));
    t = 4;
    do begin @(negedge clk); t++; end while (!per_en[0] && t < 40);
    chk("R11", "interval in progress", t, 8);
    t = 0;
    do begin @(negedge clk); t++; end while (!per_en[0] && t < 40);
    chk("R11", "first new interval", t, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule